// File: doc/BRIEF.md
# Reloadable LUT Mesh Fabric

This block is a small reconfigurable fabric for evolvable-hardware experiments. It is a fixed grid of ROWS x COLS cells, and each cell evaluates a 4-input function stored as a 16-bit truth table. The wiring between cells never changes. Every cell net has exactly one driver, so any pattern of configuration bits gives a legal circuit. An external candidate generator rewrites all truth tables at run time through a single serial shift chain. It then applies stimulus on the row inputs and reads the results from the east edge of the grid.

Each cell has four inputs: the output of its west neighbour, the output of its north neighbour, the value of its own register, and the primary input of its row. A cell in the first column takes the registered value of the east-edge cell of its row in place of a west neighbour. A cell in the first row takes the registered value of the bottom cell of its column in place of a north neighbour. These wrap-around paths always pass through a register, so the grid has no combinational loop.

Two mode bits per cell control the output. One selects whether the cell output comes from its register or directly from the table. The other turns the cell into a selector that forwards one of its four inputs, which gives a limited form of routing control.

The chain shifts one bit per clock while the load enable is high. While a load is in progress, the grid's registers are frozen and the outputs hold their last value. After the final bit has been shifted in, a one-cycle done pulse is produced and every cell register is cleared, so each candidate starts from a known state.

Top module: `lut_mesh_fabric`

## Requirements
- R1: After synchronous reset, `pOut` is all zeros and `cfgDone` is 0. The configuration after reset is all zeros, so every cell output is 0.
- R2: In table mode (selector bit 0, register bit 0), a cell's output is bit `a` of its truth table. The address `a` is built as: bit 0 = west input, bit 1 = north input, bit 2 = the cell's own register, bit 3 = the primary input `pIn[r]` of the cell's row. For column 0, the west input is the register of cell (r, COLS-1). For row 0, the north input is the register of cell (ROWS-1, c).
- R3: The configuration bit shifted in on the i-th enabled clock (counting from 0) ends up at chain position i. Cell k = r*COLS+c owns positions 18k to 18k+17. Offsets 0 to 15 hold the truth table, offset 16 is the register-select bit, and offset 17 is the selector bit.
- R4: When a cell's register-select bit is 1, its output is its register. Outside loading, the register captures the cell's table or selector result on every clock.
- R5: When a cell's selector bit is 1, the table result is replaced by the cell input whose index (0 west, 1 north, 2 own register, 3 row input) is given by truth-table bits [1:0]. Truth-table bits [15:2] have no effect in this mode.
- R6: `cfgDone` is high for exactly one cycle, namely the cycle that follows the edge on which the ROWS*COLS*18-th enabled shift occurs. Cycles with `cfgEn` low in the middle of a load do not reset the shift count, and `cfgDone` does not pulse during them.
- R7: From the first clock with `cfgEn` high until `cfgDone`, including pauses in the load, `pOut` holds the value it showed in the last evaluation cycle before the load began.
- R8: All cell registers stay frozen while a load is in progress. They are cleared to 0 on the edge that completes the load.
- R9: `pOut[r]` is the output of the east-edge cell (r, COLS-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgEn | input | 1 | Shift one configuration bit on this clock |
| cfgBit | input | 1 | Serial configuration data |
| pIn | input | ROWS | Primary input for each row |
| pOut | output | ROWS | East-edge output for each row |
| cfgDone | output | 1 | One-cycle pulse when a full load completes |

## Verification
The bench builds the fabric as a 2 x 2 grid, which gives a 72-bit chain. At this size the bench can rebuild every chain bit and model every cell and register of the grid cycle by cycle. For each of four configurations, the row inputs are swept through all four values, several times and in varying order. The configurations are pure XOR, a mixture of registered AND/OR cells, selectors with unused table bits set, and registered toggles. Together these exercise the wrap-around feedback, registered state, selector routing and load completion. One load pauses in the middle, so that the hold behaviour and the done timing are checked across a gap in the shifting.

// File: rtl/lut_mesh_pkg.sv
package lut_mesh_pkg;
  localparam int TRUTH_W = 16;
  localparam int MODE_W  = 2;
  localparam int CELL_W  = TRUTH_W + MODE_W;

  // Per-cell configuration slice, LSB first in the chain
  typedef struct packed {
    logic               selMode;
    logic               regMode;
    logic [TRUTH_W-1:0] truth;
  } cell_cfg_t;

  // Strobes from the load control to the datapath
  typedef struct packed {
    logic shift;
    logic finish;
    logic freeze;
  } strobe_t;
endpackage

// File: rtl/lut_mesh_cell.sv
module lut_mesh_cell
  import lut_mesh_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cell_cfg_t cfg,
  input  logic [3:0] nbr,
  input  logic      clear,
  input  logic      advance,
  output logic      y,
  output logic      q
);
  logic lutOut;

  always_comb begin
    if (cfg.selMode) lutOut = nbr[cfg.truth[1:0]];
    else             lutOut = cfg.truth[nbr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) q <= 1'b0;
    else if (advance) q <= lutOut;
  end

  assign y = cfg.regMode ? q : lutOut;
endmodule

// File: rtl/lut_mesh_ctrl.sv
module lut_mesh_ctrl
  import lut_mesh_pkg::*;
#(
  parameter int TOTAL = 288
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgEn,
  output strobe_t stb,
  output logic    cfgDone
);
  localparam int CNT_W = $clog2(TOTAL);

  logic [CNT_W-1:0] shiftCnt;
  logic             lastShift;

  assign lastShift = cfgEn && (shiftCnt == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftCnt <= '0;
      cfgDone  <= 1'b0;
    end else begin
      cfgDone <= lastShift;
      if (lastShift)  shiftCnt <= '0;
      else if (cfgEn) shiftCnt <= shiftCnt + 1'b1;
    end
  end

  always_comb begin
    stb.shift  = cfgEn;
    stb.finish = lastShift;
    stb.freeze = cfgEn || (shiftCnt != '0);
  end
endmodule

// File: rtl/lut_mesh_datapath.sv
module lut_mesh_datapath
  import lut_mesh_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgBit,
  input  strobe_t              stb,
  input  logic [ROWS-1:0]      pIn,
  output logic [ROWS-1:0]      pOut,
  output logic [ROWS*COLS-1:0] qFlat
);
  localparam int CELLS   = ROWS * COLS;
  localparam int CHAIN_W = CELLS * CELL_W;

  logic [CHAIN_W-1:0] chain;
  logic               yArr [ROWS][COLS];
  logic               qArr [ROWS][COLS];
  logic [ROWS-1:0]    liveOut;
  logic [ROWS-1:0]    heldOut;

  // Serial load chain: newest bit enters at the top
  always_ff @(posedge clk) begin
    if (rst)            chain <= '0;
    else if (stb.shift) chain <= {cfgBit, chain[CHAIN_W-1:1]};
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      logic       westIn;
      logic       northIn;
      logic [3:0] nbr;

      // Wrap-around paths always come from a register
      if (c == 0) begin : g_wwrap
        assign westIn = qArr[r][COLS-1];
      end else begin : g_wlink
        assign westIn = yArr[r][c-1];
      end
      if (r == 0) begin : g_nwrap
        assign northIn = qArr[ROWS-1][c];
      end else begin : g_nlink
        assign northIn = yArr[r-1][c];
      end

      assign nbr = {pIn[r], qArr[r][c], northIn, westIn};

      lut_mesh_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cell_cfg_t'(chain[K*CELL_W +: CELL_W])),
        .nbr     (nbr),
        .clear   (stb.finish),
        .advance (!stb.freeze),
        .y       (yArr[r][c]),
        .q       (qArr[r][c])
      );

      assign qFlat[K] = qArr[r][c];
    end
    assign liveOut[r] = yArr[r][COLS-1];
  end

  always_ff @(posedge clk) begin
    if (rst)              heldOut <= '0;
    else if (!stb.freeze) heldOut <= liveOut;
  end

  assign pOut = stb.freeze ? heldOut : liveOut;
endmodule

// File: rtl/lut_mesh_fabric.sv
module lut_mesh_fabric
  import lut_mesh_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgEn,
  input  logic            cfgBit,
  input  logic [ROWS-1:0] pIn,
  output logic [ROWS-1:0] pOut,
  output logic            cfgDone
);
  localparam int TOTAL = ROWS * COLS * CELL_W;

  strobe_t              stb;
  logic [ROWS*COLS-1:0] qFlat;

  lut_mesh_ctrl #(.TOTAL(TOTAL)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgEn   (cfgEn),
    .stb     (stb),
    .cfgDone (cfgDone)
  );

  lut_mesh_datapath #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .cfgBit (cfgBit),
    .stb    (stb),
    .pIn    (pIn),
    .pOut   (pOut),
    .qFlat  (qFlat)
  );
endmodule

// File: rtl/lut_mesh_checker.sv
module lut_mesh_checker #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfgEn,
  input logic                 cfgDone,
  input logic [ROWS-1:0]      pOut,
  input logic [ROWS*COLS-1:0] qFlat
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pOut == '0 && !cfgDone)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfgDone |=> !cfgDone); // R6

  AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    cfgDone |-> $past(cfgEn)); // R6

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfgEn && $past(cfgEn)) |-> $stable(pOut)); // R7

  AST_REG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    cfgDone |-> (qFlat == '0)); // R8

  AST_REG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(cfgEn) && !cfgDone) |-> $stable(qFlat)); // R8
endmodule

bind lut_mesh_fabric lut_mesh_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfgEn   (cfgEn),
  .cfgDone (cfgDone),
  .pOut    (pOut),
  .qFlat   (qFlat)
);

// File: tb/lut_mesh_fabric_bench.sv
module lut_mesh_fabric_bench;
  localparam int ROWS   = 2;
  localparam int COLS   = 2;
  localparam int CELLS  = ROWS * COLS;
  localparam int CELL_W = 18;
  localparam int TOTAL  = CELLS * CELL_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfgEn = 1'b0;
  logic            cfgBit = 1'b0;
  logic [ROWS-1:0] pIn = '0;
  logic [ROWS-1:0] pOut;
  logic            cfgDone;

  always #2 clk = ~clk;

  lut_mesh_fabric #(.ROWS(ROWS), .COLS(COLS)) u_lut_mesh_fabric (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .pIn(pIn), .pOut(pOut), .cfgDone(cfgDone)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0]     mTruth [CELLS];
  logic            mReg   [CELLS];
  logic            mSel   [CELLS];
  logic            mq     [CELLS];
  logic            mLut   [CELLS];
  logic [ROWS-1:0] lastOut;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Grid model evaluated in row-major order (links only run east and south)
  function automatic logic [ROWS-1:0] model(input logic [ROWS-1:0] pi);
    logic            yv [CELLS];
    logic [ROWS-1:0] o;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int k;
        logic [3:0] nb;
        k = r * COLS + c;
        nb[0] = (c == 0) ? mq[r*COLS + COLS-1] : yv[k-1];
        nb[1] = (r == 0) ? mq[(ROWS-1)*COLS + c] : yv[k-COLS];
        nb[2] = mq[k];
        nb[3] = pi[r];
        mLut[k] = mSel[k] ? nb[mTruth[k][1:0]] : mTruth[k][nb];
        yv[k]   = mReg[k] ? mq[k] : mLut[k];
      end
    end
    for (int r = 0; r < ROWS; r++) o[r] = yv[r*COLS + COLS-1];
    return o;
  endfunction

  task automatic evalCycle(input logic [ROWS-1:0] pi, input string req);
    logic [ROWS-1:0] e;
    @(negedge clk);
    pIn = pi;
    #1;
    e = model(pi);
    chk(req, pOut, e);
    lastOut = e;
    for (int k = 0; k < CELLS; k++) mq[k] = mLut[k];
  endtask

  task automatic setCell(input int k, input logic [15:0] t, input logic rg, input logic sl);
    mTruth[k] = t;
    mReg[k]   = rg;
    mSel[k]   = sl;
  endtask

  function automatic logic [15:0] tbl(input int kind);
    logic [15:0] t;
    for (int a = 0; a < 16; a++) begin
      case (kind)
        0: t[a] = a[0] ^ a[3];          // west xor row input
        1: t[a] = a[0] & a[3];          // west and row input
        2: t[a] = a[0] ^ a[1];          // west xor north
        3: t[a] = a[1] | a[3];          // north or row input
        4: t[a] = (a[0] & a[1]) | a[2]; // and of links, or own state
        default: t[a] = a[2] ^ a[3];    // toggle on row input
      endcase
    end
    return t;
  endfunction

  // R3: bit i of the shift order lands at chain position i
  task automatic loadCfg(input int pauseAt);
    for (int i = 0; i < TOTAL; i++) begin
      int   k;
      int   off;
      logic b;
      k   = i / CELL_W;
      off = i % CELL_W;
      b   = (off < 16) ? mTruth[k][off] : ((off == 16) ? mReg[k] : mSel[k]);
      if (i == pauseAt) begin
        repeat (3) begin
          @(negedge clk);
          cfgEn = 1'b0;
          #1;
          chk("R7 hold during pause", pOut, lastOut);
          chk("R6 no done during pause", cfgDone, 0);
        end
      end
      @(negedge clk);
      cfgEn  = 1'b1;
      cfgBit = b;
      #1;
      chk("R7 hold while shifting", pOut, lastOut);
      chk("R6 no early done", cfgDone, 0);
    end
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    chk("R6 done after last shift", cfgDone, 1);
    for (int k = 0; k < CELLS; k++) mq[k] = 1'b0;
    evalCycle(pIn, "R8 registers cleared at load end");
    chk("R6 done lasts one cycle", cfgDone, 0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) evalCycle(ROWS'((i * 3 + (i >> 2)) % 4), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < CELLS; k++) begin
      setCell(k, 16'h0000, 1'b0, 1'b0);
      mq[k] = 1'b0;
    end
    lastOut = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset output", pOut, 0);
    chk("R1 reset done", cfgDone, 0);
    for (int i = 0; i < 4; i++) evalCycle(ROWS'(i), "R1 zero config");

    // Config A: every cell xor of west and row input
    for (int k = 0; k < CELLS; k++) setCell(k, tbl(0), 1'b0, 1'b0);
    loadCfg(-1);
    sweep("R2 R3 R9 xor mesh");

    // Config B: mixed registered and table cells
    setCell(0, tbl(1), 1'b1, 1'b0);
    setCell(1, tbl(2), 1'b0, 1'b0);
    setCell(2, tbl(3), 1'b1, 1'b0);
    setCell(3, tbl(4), 1'b0, 1'b0);
    loadCfg(-1);
    sweep("R2 R4 mixed registered");

    // Config C: selectors with junk in unused table bits, paused load
    setCell(0, 16'hA5F3, 1'b0, 1'b1);
    setCell(1, 16'h5A0C, 1'b0, 1'b1);
    setCell(2, 16'hFFF1, 1'b1, 1'b1);
    setCell(3, 16'h3C32, 1'b0, 1'b1);
    loadCfg(30);
    sweep("R5 selector routing");

    // Config D: registered toggles driven by row inputs
    for (int k = 0; k < CELLS; k++) setCell(k, tbl(5), 1'b1, 1'b0);
    loadCfg(-1);
    sweep("R4 R9 registered toggle");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule